// File: doc/BRIEF.md
# Two-Port Shared Memory with Same-Word Collision Arbitration

This block is a 4096-word memory with two ports, left and right. Each port works on its own and has its own address, select, read/write control, output enable and data path. Either port can read or write any word. All inputs are sampled on one shared clock. A read returns registered data one cycle after the access.

When both ports select the same word in the same cycle, the block arbitrates. One port loses. The loser's write is dropped and its read is reported as invalid. The rule that picks the loser:
- A port that already held that word in the previous cycle keeps it.
- When the two ports arrive together, the left port wins.

A mode input sets how busy is handled:
- **Master mode:** the instance arbitrates itself and pulls the loser's busy line low. The busy line is modelled as open-drain.
- **Slave mode:** the instance never drives busy. It obeys busy lines supplied from outside, so several instances can be ganged into a wider word under one arbiter.

Top module: `dual_port_arb_ram`

## Requirements
- R1: A word written through either port at a 12-bit address (0..4095) is returned by a later read of that address from either port. The data width is the parameter DATA_W, which supports 8 or 9.
- R2: A read access is signalled by select low, read/write high (1 = read, 0 = write) and output enable low. Its data and a valid flag of 1 appear after the next rising clock edge. In every other case the valid flag is 0 after that edge, including writes, an output enable held high, and an idle port.
- R3: In one cycle, accesses of the two ports to different addresses never interfere. Two writes to different addresses both complete.
- R4: In master mode, when both ports select the same address in the same cycle and neither held it in the previous cycle, the left port wins. The right busy pull output is 1 in that same cycle, and the right write is dropped.
- R5: In master mode, when a collision occurs and exactly one port was already selecting that same address in the previous cycle, that port wins and the other port's busy pull is 1.
- R6: In master mode, while both ports keep selecting the same address across consecutive cycles, the port that lost in the first collision cycle stays the loser.
- R7: A port that has busy asserted gets no valid read data (valid flag 0 after the edge).
- R8: In slave mode (masterMode = 0), both busy pull outputs stay 0. A port whose busy input is low has its write dropped and its read invalid. A port whose busy input is high behaves normally, even on a same-address collision.
- R9: In master mode, the busy inputs have no effect on any access.
- R10: While reset is active and right after it, both valid flags and both busy pull outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rstN | input | 1 | Asynchronous reset, active low |
| masterMode | input | 1 | 1 = arbitrate locally, 0 = obey external busy |
| lSelN | input | 1 | Left port select, active low |
| lRdWr | input | 1 | Left direction, 1 = read, 0 = write |
| lOeN | input | 1 | Left output enable, active low |
| lAddr | input | 12 | Left word address |
| lWrData | input | DATA_W | Left write data |
| lRdData | output | DATA_W | Left registered read data |
| lRdValid | output | 1 | Left read data drive enable |
| lBusyInN | input | 1 | Left busy from external arbiter, active low (slave mode) |
| lBusyPull | output | 1 | 1 = pull left busy line low (open-drain model) |
| rSelN | input | 1 | Right port select, active low |
| rRdWr | input | 1 | Right direction, 1 = read, 0 = write |
| rOeN | input | 1 | Right output enable, active low |
| rAddr | input | 12 | Right word address |
| rWrData | input | DATA_W | Right write data |
| rRdData | output | DATA_W | Right registered read data |
| rRdValid | output | 1 | Right read data drive enable |
| rBusyInN | input | 1 | Right busy from external arbiter, active low (slave mode) |
| rBusyPull | output | 1 | 1 = pull right busy line low (open-drain model) |

## Verification
The storage path and the arbiter meet in one cycle whenever the two ports present the same address: a write or read takes place while busy is being decided for it. The bench provokes this in three ways:
- both ports writing the same word from idle;
- one port reading while the other writes that word;
- one port holding a word while the other arrives one cycle later and stays.

It judges each case in two steps. It samples the busy pulls before the edge. After the edge it reads the word back to confirm that only the winner's data landed and that the loser's read came back invalid. Slave-mode runs drive the busy inputs directly on a colliding pair, and a random phase on disjoint address halves is compared against a bench memory model.

// File: rtl/dpar_pkg.sv
package dpar_pkg;
  localparam int PORTS = 2;

  // per-port strobes from the arbiter to the storage path
  typedef struct packed {
    logic [PORTS-1:0] wrEn;
    logic [PORTS-1:0] rdEn;
  } strobe_t;
endpackage

// File: rtl/dpar_ctrl.sv
module dpar_ctrl
  import dpar_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          masterMode,
  input  logic [PORTS-1:0]              selN,
  input  logic [PORTS-1:0]              rdWr,
  input  logic [PORTS-1:0]              oeN,
  input  logic [PORTS-1:0][ADDR_W-1:0]  addr,
  input  logic [PORTS-1:0]              busyInN,
  output strobe_t                       stb,
  output logic [PORTS-1:0]              busyPull
);
  logic [PORTS-1:0]             act;
  logic [PORTS-1:0]             held;
  logic [PORTS-1:0]             lose;
  logic [PORTS-1:0]             busyEff;
  logic [PORTS-1:0]             actQ;
  logic [PORTS-1:0][ADDR_W-1:0] addrQ;
  logic [PORTS-1:0]             loseQ;
  logic                         coll;
  logic                         pastOk;

  for (genvar g = 0; g < PORTS; g++) begin : g_port
    assign act[g]  = ~selN[g];
    // port was already on this very word last cycle
    assign held[g] = act[g] & actQ[g] & (addrQ[g] == addr[g]);
    assign busyEff[g] = masterMode ? lose[g] : (act[g] & ~busyInN[g]);
    assign busyPull[g] = masterMode & lose[g];
    assign stb.wrEn[g] = act[g] & ~rdWr[g] & ~busyEff[g];
    assign stb.rdEn[g] = act[g] & rdWr[g] & ~oeN[g] & ~busyEff[g];
  end

  assign coll = act[0] & act[1] & (addr[0] == addr[1]);

  always_comb begin
    lose = '0;
    if (coll) begin
      unique case ({held[1], held[0]})
        2'b01:   lose = 2'b10;  // left incumbent
        2'b10:   lose = 2'b01;  // right incumbent
        2'b11:   lose = loseQ;  // sustained collision keeps its loser
        default: lose = 2'b10;  // simultaneous arrival: left wins
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actQ   <= '0;
      addrQ  <= '0;
      loseQ  <= '0;
      pastOk <= 1'b0;
    end else begin
      actQ   <= act;
      addrQ  <= addr;
      loseQ  <= lose;
      pastOk <= 1'b1;
    end
  end

  // R4: at most one loser at a time
  p_single_loser_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(busyPull[0] && busyPull[1]));

  // R4: no busy without a same-address pair
  p_no_false_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busyPull != 2'b00) |-> (!selN[0] && !selN[1] && addr[0] == addr[1]));

  // R8: slave never pulls busy
  p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (busyPull == 2'b00));

  // R5: right incumbent beats a newly arriving left port
  p_incumbent_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && masterMode && !selN[0] && !selN[1] && addr[0] == addr[1]
     && !$past(selN[1]) && $past(addr[1]) == addr[1]
     && !(!$past(selN[0]) && $past(addr[0]) == addr[0]))
    |-> busyPull[0]);
endmodule

// File: rtl/dpar_data.sv
module dpar_data
  import dpar_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       stb,
  input  logic [PORTS-1:0][ADDR_W-1:0]  addr,
  input  logic [PORTS-1:0][DATA_W-1:0]  wrData,
  output logic [PORTS-1:0][DATA_W-1:0]  rdData,
  output logic [PORTS-1:0]              rdValid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < PORTS; i++) begin
      if (stb.wrEn[i]) mem[addr[i]] <= wrData[i];
    end
  end

  for (genvar g = 0; g < PORTS; g++) begin : g_rd
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdValid[g] <= 1'b0;
        rdData[g]  <= '0;
      end else begin
        rdValid[g] <= stb.rdEn[g];
        if (stb.rdEn[g]) rdData[g] <= mem[addr[g]];
      end
    end
  end

  // R2: valid data only follows a granted read strobe
  p_valid_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid[0] |-> $past(stb.rdEn[0]));
  p_valid_source_r2b: assert property (@(posedge clk) disable iff (!rstN)
    rdValid[1] |-> $past(stb.rdEn[1]));

  // R3: a port never writes and reads in the same cycle
  p_rw_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrEn[0] && stb.rdEn[0]) && !(stb.wrEn[1] && stb.rdEn[1]));
endmodule

// File: rtl/dual_port_arb_ram.sv
module dual_port_arb_ram
  import dpar_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              lSelN,
  input  logic              lRdWr,
  input  logic              lOeN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWrData,
  output logic [DATA_W-1:0] lRdData,
  output logic              lRdValid,
  input  logic              lBusyInN,
  output logic              lBusyPull,
  input  logic              rSelN,
  input  logic              rRdWr,
  input  logic              rOeN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] rRdData,
  output logic              rRdValid,
  input  logic              rBusyInN,
  output logic              rBusyPull
);
  strobe_t                      stb;
  logic [PORTS-1:0][ADDR_W-1:0] addr;
  logic [PORTS-1:0][DATA_W-1:0] wrData;
  logic [PORTS-1:0][DATA_W-1:0] rdData;
  logic [PORTS-1:0]             rdValid;
  logic [PORTS-1:0]             busyPull;

  assign addr   = {rAddr, lAddr};
  assign wrData = {rWrData, lWrData};

  dpar_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .selN({rSelN, lSelN}), .rdWr({rRdWr, lRdWr}), .oeN({rOeN, lOeN}),
    .addr(addr), .busyInN({rBusyInN, lBusyInN}),
    .stb(stb), .busyPull(busyPull)
  );

  dpar_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid)
  );

  assign lRdData   = rdData[0];
  assign rRdData   = rdData[1];
  assign lRdValid  = rdValid[0];
  assign rRdValid  = rdValid[1];
  assign lBusyPull = busyPull[0];
  assign rBusyPull = busyPull[1];
endmodule

// File: tb/dual_port_arb_ram_bench.sv
module dual_port_arb_ram_bench;
  localparam int AW = 12;
  localparam int DW = 9;

  logic clk = 1'b0, rstN = 1'b0, masterMode = 1'b1;
  logic lSelN = 1, lRdWr = 1, lOeN = 1, lBusyInN = 1;
  logic rSelN = 1, rRdWr = 1, rOeN = 1, rBusyInN = 1;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic [DW-1:0] lWrData = '0, rWrData = '0;
  logic [DW-1:0] lRdData, rRdData;
  logic lRdValid, rRdValid, lBusyPull, rBusyPull;

  int nChk = 0, nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_port_arb_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dual_port_arb_ram (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .lSelN(lSelN), .lRdWr(lRdWr), .lOeN(lOeN), .lAddr(lAddr), .lWrData(lWrData),
    .lRdData(lRdData), .lRdValid(lRdValid), .lBusyInN(lBusyInN), .lBusyPull(lBusyPull),
    .rSelN(rSelN), .rRdWr(rRdWr), .rOeN(rOeN), .rAddr(rAddr), .rWrData(rWrData),
    .rRdData(rRdData), .rRdValid(rRdValid), .rBusyInN(rBusyInN), .rBusyPull(rBusyPull)
  );

  // op: 0 idle, 1 read, 2 write
  typedef struct packed {
    logic [1:0] lOp; logic [AW-1:0] lA; logic [DW-1:0] lD;
    logic [1:0] rOp; logic [AW-1:0] rA; logic [DW-1:0] rD;
    logic eLB; logic eRB;
    logic eLV; logic [DW-1:0] eLD;
    logic eRV; logic [DW-1:0] eRD;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd2, 12'h010, 9'h055, 2'd2, 12'h020, 9'h0AA, 1'b0, 1'b0, 1'b0, 9'h000, 1'b0, 9'h000},
    '{2'd2, 12'h030, 9'h011, 2'd2, 12'h030, 9'h122, 1'b0, 1'b1, 1'b0, 9'h000, 1'b0, 9'h000},
    '{2'd1, 12'h010, 9'h000, 2'd1, 12'h020, 9'h000, 1'b0, 1'b0, 1'b1, 9'h055, 1'b1, 9'h0AA},
    '{2'd1, 12'h030, 9'h000, 2'd1, 12'h030, 9'h000, 1'b0, 1'b1, 1'b1, 9'h011, 1'b0, 9'h000},
    '{2'd1, 12'h020, 9'h000, 2'd2, 12'h020, 9'h1F0, 1'b0, 1'b1, 1'b1, 9'h0AA, 1'b0, 9'h000},
    '{2'd0, 12'h000, 9'h000, 2'd1, 12'h020, 9'h000, 1'b0, 1'b0, 1'b0, 9'h000, 1'b1, 9'h0AA}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drvL(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    lSelN = (op == 2'd0); lRdWr = (op != 2'd2); lOeN = 1'b0; lAddr = a; lWrData = d;
  endtask

  task automatic drvR(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    rSelN = (op == 2'd0); rRdWr = (op != 2'd2); rOeN = 1'b0; rAddr = a; rWrData = d;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    drvL(2'd0, '0, '0); drvR(2'd0, '0, '0); tick();
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  logic [DW-1:0] refMem [1 << AW];
  bit            refOk  [1 << AW];

  initial begin
    #2_000_000;
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 lRdValid in reset", lRdValid, 0);
    chk("R10 busy in reset", {lBusyPull, rBusyPull}, 0);
    rstN = 1'b1;
    tick();
    chk("R10 valid after reset", {lRdValid, rRdValid}, 0);
    chk("R10 busy after reset", {lBusyPull, rBusyPull}, 0);

    // table walk: R1 R3 R4 R7
    foreach (VECS[i]) begin
      drvL(VECS[i].lOp, VECS[i].lA, VECS[i].lD);
      drvR(VECS[i].rOp, VECS[i].rA, VECS[i].rD);
      #1;
      chk($sformatf("R4 row%0d lBusyPull", i), lBusyPull, VECS[i].eLB);
      chk($sformatf("R4 row%0d rBusyPull", i), rBusyPull, VECS[i].eRB);
      tick();
      chk($sformatf("R2 R7 row%0d lRdValid", i), lRdValid, VECS[i].eLV);
      chk($sformatf("R2 R7 row%0d rRdValid", i), rRdValid, VECS[i].eRV);
      if (VECS[i].eLV) chk($sformatf("R1 R3 row%0d lRdData", i), lRdData, VECS[i].eLD);
      if (VECS[i].eRV) chk($sformatf("R1 R3 row%0d rRdData", i), rRdData, VECS[i].eRD);
      idle();
    end

    // R5 R6: right holds 0x040, left arrives a cycle later and stays
    drvR(2'd2, 12'h040, 9'h033); #1;
    chk("R5 lone right no busy", {lBusyPull, rBusyPull}, 0);
    tick();
    drvL(2'd2, 12'h040, 9'h077); drvR(2'd2, 12'h040, 9'h034); #1;
    chk("R5 left late busy", lBusyPull, 1);
    chk("R5 right incumbent free", rBusyPull, 0);
    tick();
    drvL(2'd2, 12'h040, 9'h078); drvR(2'd2, 12'h040, 9'h035); #1;
    chk("R6 sustained left busy", lBusyPull, 1);
    chk("R6 sustained right free", rBusyPull, 0);
    tick(); idle();
    drvL(2'd1, 12'h040, '0); tick();
    chk("R5 R6 incumbent data", lRdData, 9'h035);
    idle();

    // R5 mirror: left holds, right arrives later
    drvL(2'd1, 12'h041, '0); tick();
    drvR(2'd2, 12'h041, 9'h0EE); #1;
    chk("R5 right late busy", rBusyPull, 1);
    tick(); idle();

    // R2: output enable high and write give no valid
    drvL(2'd1, 12'h010, '0); lOeN = 1'b1; tick();
    chk("R2 oe high no valid", lRdValid, 0);
    drvL(2'd2, 12'h011, 9'h001); tick();
    chk("R2 write no valid", lRdValid, 0);
    idle();

    // R9: master ignores busy inputs
    lBusyInN = 1'b0; rBusyInN = 1'b0;
    drvL(2'd2, 12'h060, 9'h012); tick();
    drvL(2'd1, 12'h060, '0); tick();
    chk("R9 master ignores busy in valid", lRdValid, 1);
    chk("R9 master ignores busy in data", lRdData, 9'h012);
    lBusyInN = 1'b1; rBusyInN = 1'b1;
    idle();

    // R8: slave mode, external busy forcing on a colliding pair
    masterMode = 1'b0;
    lBusyInN = 1'b0;
    drvL(2'd2, 12'h050, 9'h0C1); drvR(2'd2, 12'h050, 9'h066); #1;
    chk("R8 slave no busy pull", {lBusyPull, rBusyPull}, 0);
    tick();
    drvL(2'd1, 12'h050, '0); drvR(2'd0, '0, '0); tick();
    chk("R8 busy-in read invalid", lRdValid, 0);
    lBusyInN = 1'b1;
    drvL(2'd1, 12'h050, '0); tick();
    chk("R8 right write landed, left dropped", lRdData, 9'h066);
    rBusyInN = 1'b0;
    drvR(2'd2, 12'h051, 9'h0AB); tick();
    rBusyInN = 1'b1;
    drvR(2'd1, 12'h051, '0); drvL(2'd2, 12'h051, 9'h0CD); tick();
    chk("R8 right read while left writes (no arbitration)", rRdValid, 1);
    idle();
    drvL(2'd1, 12'h051, '0); tick();
    chk("R8 right forced write dropped", lRdData, 9'h0CD);
    masterMode = 1'b1;
    idle();

    // R1 R3: random disjoint-half traffic against a model
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] a0, a1;
      logic [DW-1:0] d0, d1;
      logic w0, w1;
      logic [DW-1:0] e0, e1;
      a0 = {1'b0, 5'd0, 6'($urandom)};
      a1 = {1'b1, 5'd0, 6'($urandom)};
      d0 = DW'($urandom); d1 = DW'($urandom);
      w0 = !refOk[a0] || ($urandom % 2 == 0);
      w1 = !refOk[a1] || ($urandom % 2 == 0);
      e0 = refMem[a0]; e1 = refMem[a1];
      drvL(w0 ? 2'd2 : 2'd1, a0, d0);
      drvR(w1 ? 2'd2 : 2'd1, a1, d1);
      tick();
      if (w0) begin refMem[a0] = d0; refOk[a0] = 1; end
      else chk("R1 R3 random left read", {lRdValid, lRdData}, {1'b1, e0});
      if (w1) begin refMem[a1] = d1; refOk[a1] = 1; end
      else chk("R1 R3 random right read", {rRdValid, rRdData}, {1'b1, e1});
    end
    idle();

    done = 1;
    finishRun();
  end
endmodule